// File: doc/BRIEF.md
# Heterogeneous Inter-Cluster Link Steering

This block sits at the sending side of an inter-cluster interconnect. Three parallel link classes run beside each other. The fast link is narrow and short in latency. The baseline link has medium width and medium latency. The wide link is slow but moves many bits per cycle at low energy. Up to `NREQ` tagged transfers arrive each cycle on request lanes. Each transfer carries a message kind, a size in bits and a payload. The block chooses a link for each one from its kind, and keeps the bits placed on any link in one cycle within that link's width. If the preferred link is full, the transfer moves to the baseline link. If the baseline link is also full, the lane stalls.

Each link's travel time is modelled by a delay pipeline whose output tap depends on the interconnect topology: a single crossbar traversal or one ring hop. Every delivered message appears on a fixed output slot of its link. It carries its kind, size, payload, the cycle it was issued and a shared arrival timestamp. Latency-critical narrow traffic therefore lands early. Operands already ready at dispatch and store data ride the wide link, where the extra delay is hidden.

Top module: `lnk_hetero_steer`

## Requirements
- R1: Kinds 1 (early partial address) and 2 (narrow operand) prefer link 0, the fast link, which is 18 bits wide; only these kinds are ever delivered on link 0.
- R2: Kinds 3 (operand ready at dispatch) and 4 (store data) prefer link 2, the wide low-power link, which is 144 bits wide; only these kinds are ever delivered on link 2.
- R3: Kind 0 (general value) and any unlisted kind prefer link 1, the baseline link, which is 72 bits wide; kind 0 is never delivered on link 0 or link 2.
- R4: In any one cycle, the summed sizes of the messages accepted onto a link never exceed that link's width; a message whose size equals the space left still fits.
- R5: When a message does not fit in the space left on its preferred link, it is sent on link 1 if it fits there.
- R6: A valid lane that fits neither its preferred link nor link 1 gets in_ready low. Every later lane in the same cycle also gets in_ready low, while a lane that is not valid blocks nothing. in_ready is high only for valid lanes that are accepted.
- R7: With ring_mode low (crossbar), a message accepted in cycle c is delivered in cycle c+1 on link 0, c+2 on link 1 and c+3 on link 2.
- R8: With ring_mode high (one ring hop), the delivery delays are 2, 4 and 6 cycles for links 0, 1 and 2.
- R9: Messages on one link keep issue order. Messages accepted in the same cycle fill output slots link*NREQ+0 upward in lane order, and a higher slot of a link is never valid while a lower one is empty.
- R10: Every delivery carries its issue cycle on out_issue_t. out_arr_t shows the current cycle, counted from 0 in the first cycle after reset.
- R11: During reset and after it, no slot is valid until new traffic is accepted, and messages in flight when reset is applied are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_mode | input | 1 | 0 selects crossbar latencies, 1 selects ring-hop latencies; changed only while no message is in flight |
| in_valid | input | NREQ | Transfer request valid per lane |
| in_kind | input | NREQ x 3 | Message kind per lane |
| in_size | input | NREQ x 8 | Message size in bits per lane, 1 to 144 |
| in_data | input | NREQ x 144 | Payload per lane |
| in_ready | output | NREQ | Lane accepted this cycle |
| out_valid | output | 3*NREQ | Delivery valid per output slot, slot index link*NREQ+position |
| out_kind | output | 3*NREQ x 3 | Kind of the delivered message |
| out_size | output | 3*NREQ x 8 | Size of the delivered message |
| out_data | output | 3*NREQ x 144 | Payload of the delivered message |
| out_issue_t | output | 3*NREQ x 16 | Cycle in which the message was accepted |
| out_arr_t | output | 16 | Current cycle, the arrival stamp of every delivery this cycle |

## Verification
The bench aims at exact capacity boundaries. An 18-bit partial address fills the fast link exactly, two 10-bit narrow operands overflow it by two bits, and a 144-bit store fills the wide link. An off-by-one comparison would either reject the exact fit or overload the link. Fallback cases send the second lane to the baseline slot. A design that dropped the lane, or placed it in the wrong slot, would show a missing or misplaced delivery. The stall cases include one where lane 0 blocks a lane 1 that would fit; a design that let lane 1 through would break issue order. Every delivery is timed against both latency tables, and a reset with a six-cycle wide-link message in flight must deliver nothing, so a wrong tap or a pipeline left uncleared shows up as an early, late or ghost arrival.

// File: rtl/lhs_pkg.sv
package lhs_pkg;

    localparam int NLINK  = 3;
    localparam int KIND_W = 3;
    localparam int SIZE_W = 8;
    localparam int DATA_W = 144;
    localparam int TS_W   = 16;
    localparam int USED_W = 10;

    localparam logic [1:0] LNK_FAST = 2'd0;
    localparam logic [1:0] LNK_BASE = 2'd1;
    localparam logic [1:0] LNK_WIDE = 2'd2;
    localparam logic [1:0] LNK_NONE = 2'd3;

    typedef enum logic [KIND_W-1:0] {
        K_GENERAL   = 3'd0,
        K_PART_ADDR = 3'd1,
        K_NARROW    = 3'd2,
        K_READY_OPD = 3'd3,
        K_STORE     = 3'd4
    } kind_e;

    typedef struct packed {
        logic              vld;
        logic [KIND_W-1:0] kind;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   issue;
    } msg_t;

    // bits a link carries per cycle
    function automatic int link_width(input int lnk);
        case (lnk)
            0:       return 18;
            1:       return 72;
            default: return 144;
        endcase
    endfunction

    // crossbar: 1/2/3 cycles, one ring hop: twice that
    function automatic int link_lat(input int lnk, input logic ring);
        return ring ? 2 * (lnk + 1) : (lnk + 1);
    endfunction

    function automatic logic [1:0] pref_link(input logic [KIND_W-1:0] k);
        case (k)
            K_PART_ADDR, K_NARROW: return LNK_FAST;
            K_READY_OPD, K_STORE:  return LNK_WIDE;
            default:               return LNK_BASE;
        endcase
    endfunction

    function automatic logic fits(input logic [USED_W-1:0] used,
                                  input logic [SIZE_W-1:0] sz,
                                  input logic [1:0]        lnk);
        return (used + USED_W'(sz)) <= USED_W'(link_width(int'(lnk)));
    endfunction

endpackage

// File: rtl/lhs_alloc.sv
module lhs_alloc
    import lhs_pkg::*;
#(
    parameter int NREQ = 2
) (
    input  logic [NREQ-1:0]                   in_valid,
    input  logic [NREQ-1:0][KIND_W-1:0]       in_kind,
    input  logic [NREQ-1:0][SIZE_W-1:0]       in_size,
    input  logic [NREQ-1:0][DATA_W-1:0]       in_data,
    input  logic [TS_W-1:0]                   now,
    output logic [NREQ-1:0]                   in_ready,
    output msg_t [NLINK-1:0][NREQ-1:0]        link_in
);

    localparam int SLOT_W = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [USED_W-1:0] used [NLINK];
    logic [SLOT_W:0]   fill [NLINK];
    logic              blocked;
    logic [1:0]        pick;
    logic [1:0]        pref;
    msg_t              m;

    always_comb begin
        blocked  = 1'b0;
        in_ready = '0;
        link_in  = '0;
        pick     = LNK_NONE;
        pref     = LNK_BASE;
        m        = '0;
        for (int l = 0; l < NLINK; l++) begin
            used[l] = '0;
            fill[l] = '0;
        end
        for (int i = 0; i < NREQ; i++) begin
            pick = LNK_NONE;
            pref = pref_link(in_kind[i]);
            if (in_valid[i] && !blocked) begin
                if (fits(used[pref], in_size[i], pref))
                    pick = pref;
                else if (fits(used[LNK_BASE], in_size[i], LNK_BASE))
                    pick = LNK_BASE;
                else
                    blocked = 1'b1;
            end
            if (pick != LNK_NONE) begin
                m.vld   = 1'b1;
                m.kind  = in_kind[i];
                m.size  = in_size[i];
                m.data  = in_data[i];
                m.issue = now;
                in_ready[i] = 1'b1;
                link_in[pick][fill[pick][SLOT_W-1:0]] = m;
                used[pick] = used[pick] + USED_W'(in_size[i]);
                fill[pick] = fill[pick] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lhs_delay.sv
module lhs_delay
    import lhs_pkg::*;
#(
    parameter int LINK = 0,
    parameter int NREQ = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ring_mode,
    input  msg_t [NREQ-1:0]       d_in,
    output msg_t [NREQ-1:0]       d_out
);

    localparam int DEPTH  = link_lat(LINK, 1'b1);
    localparam int TAP_XB = link_lat(LINK, 1'b0) - 1;
    localparam int TAP_RG = DEPTH - 1;

    msg_t [NREQ-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d_in;
    end

    for (genvar d = 1; d < DEPTH; d++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[d] <= '0;
            else     stage[d] <= stage[d-1];
        end
    end

    assign d_out = ring_mode ? stage[TAP_RG] : stage[TAP_XB];

endmodule

// File: rtl/lnk_hetero_steer.sv
module lnk_hetero_steer
    import lhs_pkg::*;
#(
    parameter int NREQ = 2
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    ring_mode,
    input  logic [NREQ-1:0]                         in_valid,
    input  logic [NREQ-1:0][KIND_W-1:0]             in_kind,
    input  logic [NREQ-1:0][SIZE_W-1:0]             in_size,
    input  logic [NREQ-1:0][DATA_W-1:0]             in_data,
    output logic [NREQ-1:0]                         in_ready,
    output logic [NLINK*NREQ-1:0]                   out_valid,
    output logic [NLINK*NREQ-1:0][KIND_W-1:0]       out_kind,
    output logic [NLINK*NREQ-1:0][SIZE_W-1:0]       out_size,
    output logic [NLINK*NREQ-1:0][DATA_W-1:0]       out_data,
    output logic [NLINK*NREQ-1:0][TS_W-1:0]         out_issue_t,
    output logic [TS_W-1:0]                         out_arr_t
);

    logic [TS_W-1:0]            cyc;
    msg_t [NLINK-1:0][NREQ-1:0] link_in;
    msg_t [NLINK-1:0][NREQ-1:0] link_out;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + 1'b1;
    end

    lhs_alloc #(.NREQ(NREQ)) u_alloc (
        .in_valid (in_valid),
        .in_kind  (in_kind),
        .in_size  (in_size),
        .in_data  (in_data),
        .now      (cyc),
        .in_ready (in_ready),
        .link_in  (link_in)
    );

    for (genvar l = 0; l < NLINK; l++) begin : g_link
        lhs_delay #(.LINK(l), .NREQ(NREQ)) u_delay (
            .clk       (clk),
            .rst       (rst),
            .ring_mode (ring_mode),
            .d_in      (link_in[l]),
            .d_out     (link_out[l])
        );
        for (genvar s = 0; s < NREQ; s++) begin : g_slot
            assign out_valid[l*NREQ+s]   = link_out[l][s].vld;
            assign out_kind[l*NREQ+s]    = link_out[l][s].kind;
            assign out_size[l*NREQ+s]    = link_out[l][s].size;
            assign out_data[l*NREQ+s]    = link_out[l][s].data;
            assign out_issue_t[l*NREQ+s] = link_out[l][s].issue;
        end
    end

    assign out_arr_t = cyc;

endmodule

// File: rtl/lhs_chk.sv
module lhs_chk
    import lhs_pkg::*;
#(
    parameter int NREQ = 2
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              ring_mode,
    input logic [NREQ-1:0]                   in_valid,
    input logic [NREQ-1:0]                   in_ready,
    input logic [NLINK*NREQ-1:0]             out_valid,
    input logic [NLINK*NREQ-1:0][KIND_W-1:0] out_kind,
    input logic [NLINK*NREQ-1:0][SIZE_W-1:0] out_size,
    input logic [NLINK*NREQ-1:0][TS_W-1:0]   out_issue_t,
    input logic [TS_W-1:0]                   out_arr_t
);

    for (genvar l = 0; l < NLINK; l++) begin : g_l
        logic [USED_W-1:0] bits;
        always_comb begin
            bits = '0;
            for (int s = 0; s < NREQ; s++)
                if (out_valid[l*NREQ+s]) bits = bits + USED_W'(out_size[l*NREQ+s]);
        end

        p_link_cap_r4: assert property (@(posedge clk) disable iff (rst)
            bits <= USED_W'(link_width(l)));

        for (genvar s = 0; s < NREQ; s++) begin : g_s
            // R7 in crossbar mode, R8 in ring mode
            p_arrival_r7: assert property (@(posedge clk) disable iff (rst)
                out_valid[l*NREQ+s] |->
                    TS_W'(out_arr_t - out_issue_t[l*NREQ+s]) == TS_W'(link_lat(l, ring_mode)));

            if (l == 0) begin : g_fast
                p_fast_kind_r1: assert property (@(posedge clk) disable iff (rst)
                    out_valid[l*NREQ+s] |->
                        (out_kind[l*NREQ+s] == K_PART_ADDR || out_kind[l*NREQ+s] == K_NARROW));
            end
            if (l == 2) begin : g_wide
                p_wide_kind_r2: assert property (@(posedge clk) disable iff (rst)
                    out_valid[l*NREQ+s] |->
                        (out_kind[l*NREQ+s] == K_READY_OPD || out_kind[l*NREQ+s] == K_STORE));
            end
            if (l != 1) begin : g_gen
                p_general_base_r3: assert property (@(posedge clk) disable iff (rst)
                    !(out_valid[l*NREQ+s] && out_kind[l*NREQ+s] == K_GENERAL));
            end
            if (s > 0) begin : g_ord
                p_slot_order_r9: assert property (@(posedge clk) disable iff (rst)
                    out_valid[l*NREQ+s] |-> out_valid[l*NREQ+s-1]);
            end
        end
    end

    for (genvar i = 1; i < NREQ; i++) begin : g_lane
        p_inorder_accept_r6: assert property (@(posedge clk) disable iff (rst)
            (in_valid[i] && in_ready[i] && in_valid[i-1]) |-> in_ready[i-1]);
    end

    for (genvar i = 0; i < NREQ; i++) begin : g_rdy
        p_ready_valid_r6: assert property (@(posedge clk) disable iff (rst)
            in_ready[i] |-> in_valid[i]);
    end

endmodule

bind lnk_hetero_steer lhs_chk #(.NREQ(NREQ)) u_lhs_chk (
    .clk         (clk),
    .rst         (rst),
    .ring_mode   (ring_mode),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_size    (out_size),
    .out_issue_t (out_issue_t),
    .out_arr_t   (out_arr_t)
);

// File: tb/test_lnk_hetero_steer.sv
module test_lnk_hetero_steer;
    import lhs_pkg::*;

    localparam int PERIOD = 10;
    localparam int NR     = 2;
    localparam int NO     = NLINK * NR;
    localparam int NVEC   = 14;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic                         ring_mode = 1'b0;
    logic [NR-1:0]                in_valid = '0;
    logic [NR-1:0][KIND_W-1:0]    in_kind = '0;
    logic [NR-1:0][SIZE_W-1:0]    in_size = '0;
    logic [NR-1:0][DATA_W-1:0]    in_data = '0;
    logic [NR-1:0]                in_ready;
    logic [NO-1:0]                out_valid;
    logic [NO-1:0][KIND_W-1:0]    out_kind;
    logic [NO-1:0][SIZE_W-1:0]    out_size;
    logic [NO-1:0][DATA_W-1:0]    out_data;
    logic [NO-1:0][TS_W-1:0]      out_issue_t;
    logic [TS_W-1:0]              out_arr_t;

    int checks = 0;
    int fails  = 0;
    logic [TS_W-1:0] tb_cyc;

    lnk_hetero_steer #(.NREQ(NR)) i_lnk_hetero_steer (
        .clk(clk), .rst(rst), .ring_mode(ring_mode),
        .in_valid(in_valid), .in_kind(in_kind), .in_size(in_size), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_kind(out_kind),
        .out_size(out_size), .out_data(out_data), .out_issue_t(out_issue_t),
        .out_arr_t(out_arr_t)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) tb_cyc <= '0;
        else     tb_cyc <= tb_cyc + 1'b1;
    end

    // ring, valid {v1,v0}, kind0, size0, kind1, size1,
    // expected ready, lane0 link/slot, lane1 link/slot (link 3 = none)
    typedef struct packed {
        logic       ring;
        logic [1:0] v;
        logic [2:0] k0;
        logic [7:0] s0;
        logic [2:0] k1;
        logic [7:0] s1;
        logic [1:0] rdy;
        logic [1:0] l0;
        logic       sl0;
        logic [1:0] l1;
        logic       sl1;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b11, 3'd1, 8'd18,  3'd0, 8'd64,  2'b11, 2'd0, 1'b0, 2'd1, 1'b0},
        '{1'b0, 2'b11, 3'd2, 8'd10,  3'd2, 8'd8,   2'b11, 2'd0, 1'b0, 2'd0, 1'b1},
        '{1'b0, 2'b11, 3'd2, 8'd10,  3'd2, 8'd10,  2'b11, 2'd0, 1'b0, 2'd1, 1'b0},
        '{1'b0, 2'b11, 3'd3, 8'd64,  3'd4, 8'd64,  2'b11, 2'd2, 1'b0, 2'd2, 1'b1},
        '{1'b0, 2'b11, 3'd4, 8'd100, 3'd4, 8'd64,  2'b11, 2'd2, 1'b0, 2'd1, 1'b0},
        '{1'b0, 2'b11, 3'd0, 8'd72,  3'd0, 8'd8,   2'b01, 2'd1, 1'b0, 2'd3, 1'b0},
        '{1'b0, 2'b11, 3'd4, 8'd144, 3'd4, 8'd100, 2'b01, 2'd2, 1'b0, 2'd3, 1'b0},
        '{1'b0, 2'b11, 3'd0, 8'd80,  3'd1, 8'd8,   2'b00, 2'd3, 1'b0, 2'd3, 1'b0},
        '{1'b0, 2'b10, 3'd0, 8'd0,   3'd2, 8'd8,   2'b10, 2'd3, 1'b0, 2'd0, 1'b0},
        '{1'b1, 2'b11, 3'd1, 8'd18,  3'd0, 8'd72,  2'b11, 2'd0, 1'b0, 2'd1, 1'b0},
        '{1'b1, 2'b11, 3'd4, 8'd144, 3'd3, 8'd8,   2'b11, 2'd2, 1'b0, 2'd1, 1'b0},
        '{1'b1, 2'b11, 3'd2, 8'd10,  3'd3, 8'd30,  2'b11, 2'd0, 1'b0, 2'd2, 1'b0},
        '{1'b0, 2'b11, 3'd3, 8'd8,   3'd2, 8'd18,  2'b11, 2'd2, 1'b0, 2'd0, 1'b0},
        '{1'b0, 2'b11, 3'd0, 8'd8,   3'd1, 8'd20,  2'b11, 2'd1, 1'b0, 2'd1, 1'b1}
    };

    // latencies from R7 / R8
    function automatic int exp_lat(input int lnk, input logic ring);
        case (lnk)
            0:       return ring ? 2 : 1;
            1:       return ring ? 4 : 2;
            default: return ring ? 6 : 3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0;
        in_kind  = '0;
        in_size  = '0;
        in_data  = '0;
    endtask

    task automatic expect_idle(input string req);
        chk(out_valid == '0, req, longint'(out_valid), 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [TS_W-1:0] issue;
        vec_t v;

        // R11: reset state
        repeat (3) @(negedge clk);
        expect_idle("R11 reset outputs");
        chk(out_arr_t == '0, "R11 stamp in reset", longint'(out_arr_t), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_arr_t == 16'd1, "R10 first stamp", longint'(out_arr_t), 1);
        expect_idle("R11 idle after reset");

        // table walk: R1..R9
        for (int vi = 0; vi < NVEC; vi++) begin
            v = VECS[vi];
            ring_mode = v.ring;
            @(negedge clk);
            in_valid = v.v;
            in_kind[0] = v.k0;  in_size[0] = v.s0;  in_data[0] = DATA_W'(vi * 16 + 1);
            in_kind[1] = v.k1;  in_size[1] = v.s1;  in_data[1] = DATA_W'(vi * 16 + 2);
            #1;
            issue = tb_cyc;
            chk(in_ready == v.rdy, $sformatf("R6 ready vec%0d", vi), longint'(in_ready), longint'(v.rdy));
            for (int k = 1; k <= 7; k++) begin
                @(negedge clk);
                if (k == 1) clear_in();
                for (int l = 0; l < NLINK; l++) begin
                    for (int s = 0; s < NR; s++) begin
                        int  idx;
                        bit  h0, h1, ev;
                        idx = l * NR + s;
                        h0 = v.rdy[0] && v.l0 == 2'(l) && v.sl0 == 1'(s);
                        h1 = v.rdy[1] && v.l1 == 2'(l) && v.sl1 == 1'(s);
                        ev = (h0 || h1) && k == exp_lat(l, v.ring);
                        chk(out_valid[idx] == ev,
                            $sformatf("R4 R5 R7 R8 R9 vec%0d slot%0d k%0d valid", vi, idx, k),
                            longint'(out_valid[idx]), longint'(ev));
                        if (ev) begin
                            chk(out_size[idx] == (h0 ? v.s0 : v.s1),
                                $sformatf("R1 R2 R3 vec%0d slot%0d size", vi, idx),
                                longint'(out_size[idx]), longint'(h0 ? v.s0 : v.s1));
                            chk(out_data[idx] == DATA_W'(vi * 16 + (h0 ? 1 : 2)),
                                $sformatf("R9 vec%0d slot%0d data", vi, idx),
                                longint'(out_data[idx][31:0]), longint'(vi * 16 + (h0 ? 1 : 2)));
                            chk(out_issue_t[idx] == issue,
                                $sformatf("R10 vec%0d slot%0d issue", vi, idx),
                                longint'(out_issue_t[idx]), longint'(issue));
                            chk(out_arr_t == issue + TS_W'(k),
                                $sformatf("R10 vec%0d arrival", vi),
                                longint'(out_arr_t), longint'(issue + TS_W'(k)));
                        end
                    end
                end
            end
        end

        // R9 R10: back-to-back narrow operands on the fast link keep order
        ring_mode = 1'b0;
        @(negedge clk);
        in_valid = 2'b01; in_kind[0] = K_NARROW; in_size[0] = 8'd8; in_data[0] = DATA_W'(16'hA1);
        #1; issue = tb_cyc;
        @(negedge clk);
        in_data[0] = DATA_W'(16'hB2);
        #1;
        chk(out_valid[0] && out_data[0] == DATA_W'(16'hA1), "R9 first in order",
            longint'(out_data[0][15:0]), 16'hA1);
        chk(out_issue_t[0] == issue, "R10 first issue", longint'(out_issue_t[0]), longint'(issue));
        @(negedge clk);
        clear_in();
        chk(out_valid[0] && out_data[0] == DATA_W'(16'hB2), "R9 second in order",
            longint'(out_data[0][15:0]), 16'hB2);
        chk(out_issue_t[0] == issue + 1'b1, "R10 second issue",
            longint'(out_issue_t[0]), longint'(issue + 1'b1));
        @(negedge clk);
        expect_idle("R9 no extra delivery");

        // R11: reset with a ring wide-link message in flight
        repeat (4) @(negedge clk);
        ring_mode = 1'b1;
        @(negedge clk);
        in_valid = 2'b01; in_kind[0] = K_STORE; in_size[0] = 8'd64; in_data[0] = DATA_W'(7);
        @(negedge clk);
        clear_in();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        expect_idle("R11 flushed during reset");
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            expect_idle("R11 no ghost delivery");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule